// File: doc/BRIEF.md
# DDR2 Mode-Register Address Override over I2C

This block sits beside a DDR2 command/address bus. While the DRAM mode registers are being set up, it can take over the row-address lines A[12:0] and the bank-address lines BA[1:0]. Software programs it over I2C through two byte-wide registers. Every bit of those registers sets the level of one address or bank pin. One enable bit chooses who owns the lines. When the bit is set, this block drives the stored pattern and opens the analog bus switches that normally join the memory controller to the DRAM. When the bit is clear, the block releases its pins and closes the switches, so the memory controller drives the bus again.

The usual sequence has four steps. Software writes the address pattern. It picks the target mode register with the bank bits (00 = MR, 01 = EMR1, 10 = EMR2, 11 = EMR3). It sets the enable bit. Then it makes the memory controller issue its load-mode command. There is no commit step: a byte that has been written reaches the pins at once. SCL and SDA are sampled by the system clock through synchronizers. SDA is driven open-drain, through a pull-down enable.

Top module: `ddr_mode_override`

## Requirements
- R1: The block answers only to 7-bit device address 50h (write byte A0h, read byte A1h) by pulling SDA low in the acknowledge slot. Any other device address gets no acknowledge, and the transaction that follows has no effect on any register.
- R2: Register address 80h holds the low address pattern: bit n drives addr_o[n] for n = 0..7.
- R3: In register address 81h, bits 4..0 drive addr_o[12:8], bit 5 drives bank_o[0] and bit 6 drives bank_o[1]. The bank value chooses the mode register: 0 = MR, 1 = EMR1, 2 = EMR2, 3 = EMR3.
- R4: Bit 7 of register 81h is the override enable. When it is 1, addr_oe_o and bus_sw_open_o are both 1. When it is 0, both are 0, and the pads release the address and bank lines. The two outputs change in the same clock cycle.
- R5: A written byte reaches the pins at most 2 clocks after the synchronized SCL falling edge that ends the byte's eighth bit, before the acknowledge slot, with no further strobe. The pins change only as the result of such a write.
- R6: After reset both registers are 00h. This means addr_o = 0, bank_o = 0, and both the enable and the switch output are low.
- R7: A data byte written to a register address other than 80h or 81h is acknowledged but changes nothing. A read from such an address returns FFh.
- R8: Reads return the current register contents. The register pointer advances by one after every data byte, whether written or read, so one transaction can cover 80h and then 81h.
- R9: The block changes its SDA pull-down only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe_o | output | 1 | Pulls SDA low when 1 |
| addr_o | output | 13 | Override pattern for A[12:0] |
| bank_o | output | 2 | Override pattern for BA[1:0] |
| addr_oe_o | output | 1 | Pad output enable for addr_o and bank_o |
| bus_sw_open_o | output | 1 | 1 opens the bus switches to the memory controller |

## Verification
The block registers SCL and SDA through SYNC_STAGES flops and one edge-detect flop. Every bus event therefore acts about three clocks after the line moves. A register write reaches the pins two clocks after that. The bench holds each SCL quarter-phase for eight clocks. It checks the pins after a stop condition, or, for R5, at the end of the low phase that follows the eighth data bit, which is well after that delay and before the acknowledge slot opens. It samples acknowledge and read bits in the middle of the SCL high phase.

// File: rtl/ddr_ovr_pkg.sv
package ddr_ovr_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_ACK_DEV,
    ST_REG,
    ST_ACK_REG,
    ST_WDATA,
    ST_ACK_W,
    ST_RDATA,
    ST_RACK
  } i2c_state_e;

  localparam int unsigned BYTE_W    = 8;
  localparam logic [7:0]  UNMAPPED  = 8'hFF;
endpackage

// File: rtl/ovr_sync.sv
module ovr_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  // idle bus level is high, so reset to ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '1;
    end else begin
      pipe_q[0] <= d_i;
      for (int s = 1; s < int'(STAGES); s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/ovr_i2c_target.sv
module ovr_i2c_target
  import ddr_ovr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic       wr_en_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wdata_o,
  output logic [7:0] rd_addr_o,
  input  logic [7:0] rdata_i
);
  i2c_state_e state_q;
  logic       scl_q, sda_q;
  logic [3:0] bit_cnt_q;
  logic [7:0] sreg_q, tx_q, ptr_q, wr_addr_q, wdata_q;
  logic       rd_mode_q, nack_q, sda_low_q, wr_en_q;
  logic       scl_rise, scl_fall, start_det, stop_det, byte_done;

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
  assign byte_done = (bit_cnt_q == 4'd8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      sreg_q    <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      wr_addr_q <= '0;
      wdata_q   <= '0;
      rd_mode_q <= 1'b0;
      nack_q    <= 1'b1;
      sda_low_q <= 1'b0;
      wr_en_q   <= 1'b0;
    end else begin
      wr_en_q <= 1'b0;
      if (start_det) begin
        state_q   <= ST_DEV;
        bit_cnt_q <= '0;
        sda_low_q <= 1'b0;
      end else if (stop_det) begin
        state_q   <= ST_IDLE;
        sda_low_q <= 1'b0;
      end else if (scl_rise) begin
        if (state_q inside {ST_DEV, ST_REG, ST_WDATA}) begin
          sreg_q    <= {sreg_q[6:0], sda_i};
          bit_cnt_q <= bit_cnt_q + 4'd1;
        end
        if (state_q == ST_RACK) nack_q <= sda_i;
      end else if (scl_fall) begin
        unique case (state_q)
          ST_DEV: if (byte_done) begin
            if (sreg_q[7:1] == DEV_ADDR) begin
              state_q   <= ST_ACK_DEV;
              rd_mode_q <= sreg_q[0];
              sda_low_q <= 1'b1;
            end else begin
              state_q <= ST_IDLE;
            end
          end
          ST_ACK_DEV: begin
            if (rd_mode_q) begin
              tx_q      <= rdata_i;
              sda_low_q <= ~rdata_i[7];
              bit_cnt_q <= 4'd1;
              state_q   <= ST_RDATA;
            end else begin
              sda_low_q <= 1'b0;
              bit_cnt_q <= '0;
              state_q   <= ST_REG;
            end
          end
          ST_REG: if (byte_done) begin
            ptr_q     <= sreg_q;
            sda_low_q <= 1'b1;
            state_q   <= ST_ACK_REG;
          end
          ST_ACK_REG, ST_ACK_W: begin
            sda_low_q <= 1'b0;
            bit_cnt_q <= '0;
            state_q   <= ST_WDATA;
          end
          ST_WDATA: if (byte_done) begin
            wr_en_q   <= 1'b1;
            wr_addr_q <= ptr_q;
            wdata_q   <= sreg_q;
            ptr_q     <= ptr_q + 8'd1;
            sda_low_q <= 1'b1;
            state_q   <= ST_ACK_W;
          end
          ST_RDATA: begin
            if (byte_done) begin
              sda_low_q <= 1'b0;
              ptr_q     <= ptr_q + 8'd1;
              state_q   <= ST_RACK;
            end else begin
              tx_q      <= {tx_q[6:0], 1'b0};
              sda_low_q <= ~tx_q[6];
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end
          end
          ST_RACK: begin
            if (!nack_q) begin
              tx_q      <= rdata_i;
              sda_low_q <= ~rdata_i[7];
              bit_cnt_q <= 4'd1;
              state_q   <= ST_RDATA;
            end else begin
              state_q <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o  = sda_low_q;
  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wdata_o   = wdata_q;
  assign rd_addr_o = ptr_q;
endmodule

// File: rtl/ovr_regfile.sv
module ovr_regfile
  import ddr_ovr_pkg::*;
#(
  parameter int unsigned NUM_REGS = 2,
  parameter logic [7:0]  BASE     = 8'h80
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [7:0]                 wr_addr_i,
  input  logic [7:0]                 wdata_i,
  input  logic [7:0]                 rd_addr_i,
  output logic [7:0]                 rdata_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
  for (genvar i = 0; i < int'(NUM_REGS); i++) begin : g_reg
    localparam logic [7:0] ADDR = BASE + 8'(i);
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           q <= '0;
      else if (wr_en_i && wr_addr_i == ADDR) q <= wdata_i;
    end
    assign regs_o[i*BYTE_W +: BYTE_W] = q;
  end

  always_comb begin
    rdata_o = UNMAPPED;
    for (int i = 0; i < int'(NUM_REGS); i++) begin
      if (rd_addr_i == BASE + 8'(i)) rdata_o = regs_o[i*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/ddr_mode_override.sv
module ddr_mode_override
  import ddr_ovr_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h50,
  parameter logic [7:0]  REG_BASE    = 8'h80,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  output logic [12:0] addr_o,
  output logic [1:0]  bank_o,
  output logic        addr_oe_o,
  output logic        bus_sw_open_o
);
  localparam int unsigned NUM_REGS = 2;

  logic [1:0] line_sync;
  logic       wr_en;
  logic [7:0] wr_addr, wdata, rd_addr, rdata;
  logic [NUM_REGS*BYTE_W-1:0] regs;
  logic [7:0] reg_lo, reg_hi;

  ovr_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_sync)
  );

  ovr_i2c_target #(.DEV_ADDR(DEV_ADDR)) u_target (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .scl_i    (line_sync[1]),
    .sda_i    (line_sync[0]),
    .sda_oe_o (sda_oe_o),
    .wr_en_o  (wr_en),
    .wr_addr_o(wr_addr),
    .wdata_o  (wdata),
    .rd_addr_o(rd_addr),
    .rdata_i  (rdata)
  );

  ovr_regfile #(.NUM_REGS(NUM_REGS), .BASE(REG_BASE)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wdata_i  (wdata),
    .rd_addr_i(rd_addr),
    .rdata_o  (rdata),
    .regs_o   (regs)
  );

  assign reg_lo = regs[7:0];
  assign reg_hi = regs[15:8];

  // enable and switch come from one flop: they cannot disagree for a cycle
  assign addr_o        = {reg_hi[4:0], reg_lo};
  assign bank_o        = reg_hi[6:5];
  assign addr_oe_o     = reg_hi[7];
  assign bus_sw_open_o = reg_hi[7];
endmodule

// File: rtl/ddr_mode_override_chk.sv
module ddr_mode_override_chk #(
  parameter logic [7:0] REG_BASE = 8'h80
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        scl_i,
  input logic        sda_oe_o,
  input logic [12:0] addr_o,
  input logic [1:0]  bank_o,
  input logic        addr_oe_o,
  input logic        bus_sw_open_o,
  input logic        wr_en,
  input logic [7:0]  wr_addr
);
  logic [7:0] hi_addr;
  assign hi_addr = REG_BASE + 8'd1;

  assert_sda_scl_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);

  assert_pins_need_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({addr_o, bank_o, addr_oe_o, bus_sw_open_o}) |-> $past(wr_en));

  assert_enable_from_hi_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({addr_oe_o, bus_sw_open_o}) |-> $past(wr_en && wr_addr == hi_addr));

  assert_unmapped_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && (wr_addr < REG_BASE || wr_addr > hi_addr))
      |=> $stable({addr_o, bank_o, addr_oe_o, bus_sw_open_o}));
endmodule

bind ddr_mode_override ddr_mode_override_chk #(.REG_BASE(REG_BASE)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .scl_i        (scl_i),
  .sda_oe_o     (sda_oe_o),
  .addr_o       (addr_o),
  .bank_o       (bank_o),
  .addr_oe_o    (addr_oe_o),
  .bus_sw_open_o(bus_sw_open_o),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr)
);

// File: tb/ddr_mode_override_bench.sv
module ddr_mode_override_bench;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [12:0] addr;
  logic [1:0] bank;
  logic addr_oe, sw_open;
  wire sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  ddr_mode_override u_ddr_mode_override (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .addr_o(addr), .bank_o(bank),
    .addr_oe_o(addr_oe), .bus_sw_open_o(sw_open)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] m_lo = 8'h00;
  logic [7:0] m_hi = 8'h00;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [12:0] exp_addr(input logic [7:0] lo, input logic [7:0] hi);
    return {hi[4:0], lo};
  endfunction

  function automatic logic [7:0] model_rd(input logic [7:0] a);
    if (a == 8'h80) return m_lo;
    if (a == 8'h81) return m_hi;
    return 8'hFF;
  endfunction

  function automatic void model_wr(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'h80) m_lo = d;
    else if (a == 8'h81) m_hi = d;
  endfunction

  task automatic check_pins(input string tag);
    chk({tag, " addr"}, 32'(addr), 32'(exp_addr(m_lo, m_hi)));
    chk({tag, " bank"}, 32'(bank), 32'(m_hi[6:5]));
    chk({tag, " oe"}, 32'(addr_oe), 32'(m_hi[7]));
    chk({tag, " sw"}, 32'(sw_open), 32'(m_hi[7]));
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2 * Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    b = sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack_n);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(ack_n);
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic nack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(nack);
  endtask

  task automatic write_regs(input string tag, input logic [7:0] ra, input int n,
                            input logic [7:0] d0, input logic [7:0] d1);
    logic a;
    i2c_start;
    send_byte(8'hA0, a); chk({tag, " R1 dev ack"}, 32'(a), 0);
    send_byte(ra, a);    chk({tag, " reg ack"}, 32'(a), 0);
    send_byte(d0, a);    chk({tag, " R7 data ack"}, 32'(a), 0);
    model_wr(ra, d0);
    if (n > 1) begin
      send_byte(d1, a);
      model_wr(ra + 8'd1, d1);
    end
    i2c_stop;
  endtask

  task automatic read_two(input string tag, input logic [7:0] ra);
    logic a;
    logic [7:0] r0, r1;
    i2c_start;
    send_byte(8'hA0, a);
    send_byte(ra, a);
    i2c_start;
    send_byte(8'hA1, a); chk({tag, " R1 read ack"}, 32'(a), 0);
    recv_byte(r0, 1'b0);
    recv_byte(r1, 1'b1);
    i2c_stop;
    chk({tag, " R8 first"}, 32'(r0), 32'(model_rd(ra)));
    chk({tag, " R8 second"}, 32'(r1), 32'(model_rd(ra + 8'd1)));
  endtask

  initial begin
    logic a;
    logic [7:0] d;
    void'($urandom(32'h5eed_0101));
    tick(10);
    rst_n = 1'b1;
    tick(4);
    // R6: reset state
    check_pins("R6 reset");
    read_two("R6 readback", 8'h80);

    // R2: low pattern, override still off
    write_regs("R2", 8'h80, 1, 8'hA5, 8'h00);
    check_pins("R2 lo");

    // R3 / R4: high register with enable
    write_regs("R3", 8'h81, 1, 8'hD5, 8'h00);
    check_pins("R3 R4 hi");

    // R3: all four mode-register selects
    for (int b = 0; b < 4; b++) begin
      write_regs("R3 bank", 8'h81, 1, 8'h8A | 8'(b << 5), 8'h00);
      chk("R3 bank sel", 32'(bank), 32'(b));
    end

    // R8: burst write then readback
    write_regs("R8 burst", 8'h80, 2, 8'h3C, 8'hE7);
    check_pins("R8 burst");
    read_two("R8 rd", 8'h80);

    // R7: unmapped write and read
    write_regs("R7 wr", 8'h90, 1, 8'h55, 8'h00);
    check_pins("R7 unmapped");
    read_two("R7 rd", 8'h81);
    read_two("R7 rd2", 8'h82);

    // R1: foreign device address
    i2c_start;
    send_byte(8'hA2, a); chk("R1 foreign nack", 32'(a), 1);
    send_byte(8'h80, a);
    send_byte(8'h00, a);
    i2c_stop;
    check_pins("R1 foreign");

    // R5: pins update before the acknowledge slot
    i2c_start;
    send_byte(8'hA0, a);
    send_byte(8'h80, a);
    d = 8'h6B;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    chk("R5 immediate", 32'(addr[7:0]), 32'(d));
    recv_bit(a);
    i2c_stop;
    model_wr(8'h80, d);

    // R4: disable hands the bus back
    write_regs("R4 off", 8'h81, 1, 8'h1F, 8'h00);
    check_pins("R4 off");

    // random mix
    for (int it = 0; it < 16; it++) begin
      int unsigned sel = $urandom % 4;
      logic [7:0] d0 = 8'($urandom);
      logic [7:0] d1 = 8'($urandom);
      case (sel)
        0: write_regs("RND R2", 8'h80, 1, d0, d1);
        1: write_regs("RND R3", 8'h81, 1, d0, d1);
        2: write_regs("RND R8", 8'h80, 2, d0, d1);
        default: write_regs("RND R7", 8'h85, 1, d0, d1);
      endcase
      check_pins("RND R4 pins");
      read_two("RND R8", 8'h80);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R5 actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule